// File: doc/BRIEF.md
# Packed Vector Shifter with Register-Sourced Count

This block shifts a 128-bit data vector as four independent 32-bit lanes, all by one common shift amount. The amount comes from a second 128-bit vector operand rather than from an immediate or from per-lane fields. Only the lower 64 bits of that operand count. They form a single unsigned integer, so a count vector that holds several small lane values usually encodes a very large shift.

Three shift kinds are offered: logical right, logical left and arithmetic right. Counts at or above the lane width saturate. A logical shift then clears the lane, and an arithmetic shift fills the lane with its sign bit. The block is purely combinational. It is meant to sit inside a vector execution pipeline between the operand read and the result register.

Top module: `vshift_packed`

## Requirements
- R1: Only count_in[63:0] sets the shift amount. Any value on count_in[127:64] has no effect on result_out.
- R2: All four lanes use the same 64-bit amount. Lane i occupies bits [32i+31:32i] of both data_in and result_out.
- R3: The amount is count_in[63:0] read as one unsigned 64-bit integer. A count vector whose 32-bit lanes are, from lane 3 down to lane 0, (2,3,1,2) gives 0x0000000100000002, and that amount saturates.
- R4: For op_sel 00 (logical right) and 01 (logical left), any amount of 32 or more makes every lane zero.
- R5: For op_sel 10 (arithmetic right), any amount of 32 or more fills each lane with copies of that lane's bit 31.
- R6: An amount of zero returns data_in unchanged for every op_sel.
- R7: The op_sel encoding is: 00 logical right, 01 logical left, 10 arithmetic right. 11 is reserved and returns data_in unchanged.
- R8: No bit moves from one lane into another for any amount. Logical left fills vacated low bits with zero. Logical right fills vacated high bits with zero.
- R9: Arithmetic right with an amount below 32 fills vacated high bits of each lane with that lane's bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 2 | Shift kind: 00 logical right, 01 logical left, 10 arithmetic right, 11 pass-through |
| data_in | input | 128 | Four 32-bit lanes to shift |
| count_in | input | 128 | Count vector; bits [63:0] give the common unsigned amount |
| result_out | output | 128 | Shifted lanes |

## Verification
The hardest case to reach from the ports is a count whose low five bits look small while higher bits of the 64-bit field are set. A design that decodes only a narrow count field would shift by the small value instead of saturating. The bench therefore builds counts from several small lane values, from single high bits between bit 5 and bit 63, and from values just below, at and just above 32. It then combines each count with sign-heavy and lane-edge data patterns, so that wrong saturation and leakage across lanes both show up at the output.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

  typedef enum logic [1:0] {
    OP_SRL  = 2'b00,
    OP_SLL  = 2'b01,
    OP_SRA  = 2'b10,
    OP_PASS = 2'b11
  } shift_op_e;

endpackage

// File: rtl/vshift_count_sat.sv
module vshift_count_sat #(
  parameter int COUNT_W = 64,
  parameter int LANE_W  = 32,
  parameter int AMT_W   = $clog2(LANE_W)
) (
  input  logic [COUNT_W-1:0] count,
  output logic [AMT_W-1:0]   amt,
  output logic               sat
);

  // Any amount that reaches the lane width empties the lane entirely.
  always_comb begin
    sat = (count >= COUNT_W'(LANE_W));
    amt = count[AMT_W-1:0];
  end

endmodule

// File: rtl/vshift_lane.sv
module vshift_lane
  import vshift_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int AMT_W  = $clog2(LANE_W)
) (
  input  shift_op_e         op,
  input  logic [LANE_W-1:0] lane_in,
  input  logic [AMT_W-1:0]  amt,
  input  logic              sat,
  output logic [LANE_W-1:0] lane_out
);

  logic                          fill;
  logic                          is_left;
  logic [LANE_W-1:0]             rev_in;
  logic [LANE_W-1:0]             pre;
  logic [LANE_W-1:0]             post;
  logic [LANE_W-1:0]             rev_post;
  logic [AMT_W:0][LANE_W-1:0]    stage;

  always_comb begin
    is_left = (op == OP_SLL);
    fill    = (op == OP_SRA) & lane_in[LANE_W-1];
    pre     = is_left ? rev_in : lane_in;
  end

  // Left shift reuses the right shifter through bit reversal.
  for (genvar i = 0; i < LANE_W; i++) begin : g_rev
    assign rev_in[i]   = lane_in[LANE_W-1-i];
    assign rev_post[i] = post[LANE_W-1-i];
  end

  assign stage[0] = pre;

  // Logarithmic right shifter: stage k moves by 2**k when amt[k] is set.
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    assign stage[k+1] = amt[k] ? {{SH{fill}}, stage[k][LANE_W-1:SH]} : stage[k];
  end

  assign post = stage[AMT_W];

  always_comb begin
    if (op == OP_PASS) begin
      lane_out = lane_in;
    end else if (sat) begin
      lane_out = {LANE_W{fill}};
    end else if (is_left) begin
      lane_out = rev_post;
    end else begin
      lane_out = post;
    end
  end

  always_comb begin
    if (sat && (op == OP_SRL || op == OP_SLL)) begin
      assert_logical_sat_zero_R4 : assert (lane_out == '0)
        else $error("logical shift with saturated amount left bits set");
    end
    if (sat && op == OP_SRA) begin
      assert_arith_sat_fill_R5 : assert (lane_out == {LANE_W{lane_in[LANE_W-1]}})
        else $error("arithmetic shift with saturated amount did not sign fill");
    end
    if (!sat && op == OP_SRA) begin
      assert_arith_sign_keep_R9 : assert (lane_out[LANE_W-1] == lane_in[LANE_W-1])
        else $error("arithmetic shift changed the lane sign");
    end
  end

endmodule

// File: rtl/vshift_packed.sv
module vshift_packed
  import vshift_pkg::*;
#(
  parameter int LANE_W  = 32,
  parameter int LANES   = 4,
  parameter int COUNT_W = 64
) (
  input  logic [1:0]                op_sel,
  input  logic [LANE_W*LANES-1:0]   data_in,
  input  logic [LANE_W*LANES-1:0]   count_in,
  output logic [LANE_W*LANES-1:0]   result_out
);

  localparam int VEC_W = LANE_W * LANES;
  localparam int AMT_W = $clog2(LANE_W);

  shift_op_e          op;
  logic [COUNT_W-1:0] count_lo;
  logic [AMT_W-1:0]   amt;
  logic               sat;

  assign op       = shift_op_e'(op_sel);
  assign count_lo = count_in[COUNT_W-1:0];

  vshift_count_sat #(
    .COUNT_W (COUNT_W),
    .LANE_W  (LANE_W),
    .AMT_W   (AMT_W)
  ) u_count (
    .count (count_lo),
    .amt   (amt),
    .sat   (sat)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    vshift_lane #(
      .LANE_W (LANE_W),
      .AMT_W  (AMT_W)
    ) u_lane (
      .op       (op),
      .lane_in  (data_in[l*LANE_W +: LANE_W]),
      .amt      (amt),
      .sat      (sat),
      .lane_out (result_out[l*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    if (count_lo == '0) begin
      assert_zero_count_identity_R6 : assert (result_out == data_in)
        else $error("zero amount altered the data");
    end
    if (op_sel == 2'b11) begin
      assert_reserved_pass_R7 : assert (result_out == data_in)
        else $error("reserved op did not pass data through");
    end
  end

  if (VEC_W < COUNT_W) begin : g_bad_cfg
    initial $error("count field wider than the vector");
  end

endmodule

// File: tb/vshift_packed_tb.sv
module vshift_packed_tb;

  logic         clk;
  logic         rst_n;
  logic [1:0]   op_sel;
  logic [127:0] data_in;
  logic [127:0] count_in;
  logic [127:0] result_out;

  int checks;
  int errors;
  logic [31:0] rng;

  vshift_packed u_dut (
    .op_sel     (op_sel),
    .data_in    (data_in),
    .count_in   (count_in),
    .result_out (result_out)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] next_rand(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  // Bit-by-bit model, one lane at a time.
  function automatic logic [127:0] model(input logic [1:0] op,
                                         input logic [127:0] d,
                                         input logic [127:0] c);
    logic [127:0] r;
    logic [63:0]  n;
    n = c[63:0];
    r = '0;
    for (int l = 0; l < 4; l++) begin
      logic [31:0] ln;
      logic [31:0] lo;
      ln = d[32*l +: 32];
      for (int b = 0; b < 32; b++) begin
        case (op)
          2'b00: lo[b] = (n < 64'(32 - b)) ? ln[b + int'(n)] : 1'b0;
          2'b01: lo[b] = (n <= 64'(b)) ? ln[b - int'(n)] : 1'b0;
          2'b10: lo[b] = (n < 64'(32 - b)) ? ln[b + int'(n)] : ln[31];
          default: lo[b] = ln[b];
        endcase
      end
      r[32*l +: 32] = lo;
    end
    return r;
  endfunction

  task automatic drive_check(input string req, input logic [1:0] op,
                             input logic [127:0] d, input logic [127:0] c);
    logic [127:0] exp;
    @(posedge clk);
    op_sel   = op;
    data_in  = d;
    count_in = c;
    @(negedge clk);
    exp = model(op, d, c);
    checks++;
    if (result_out !== exp) begin
      errors++;
      $display("FAIL %s op=%0d count=%h actual=%h expected=%h",
               req, op, c[63:0], result_out, exp);
    end
  endtask

  task automatic t_reset_state;
    @(negedge clk);
    checks++;
    if (result_out !== 128'h0) begin
      errors++;
      $display("FAIL R6 idle actual=%h expected=%h", result_out, 128'h0);
    end
  endtask

  task automatic t_zero_count;
    for (int op = 0; op < 4; op++) begin
      drive_check("R6", 2'(op), 128'hDEADBEEF_80000001_7FFFFFFF_12345678, 128'h0);
    end
  endtask

  task automatic t_ops_small;
    drive_check("R7", 2'b00, 128'hF000000F_80000000_00000001_AAAA5555, 128'd4);
    drive_check("R7", 2'b01, 128'hF000000F_80000000_00000001_AAAA5555, 128'd4);
    drive_check("R9", 2'b10, 128'hF000000F_80000000_7FFFFFFF_AAAA5555, 128'd4);
    drive_check("R7", 2'b11, 128'hF000000F_80000000_00000001_AAAA5555, 128'd4);
  endtask

  task automatic t_boundary;
    for (int n = 30; n <= 34; n++) begin
      for (int op = 0; op < 3; op++) begin
        drive_check(op == 2 ? "R5" : "R4", 2'(op),
                    128'h80000001_7FFFFFFE_FFFFFFFF_00000001, 128'(n));
      end
    end
  endtask

  task automatic t_lanes_as_count;
    // Lanes 3..0 = 2,3,1,2 give low 64 bits 0x0000000100000002.
    logic [127:0] cv;
    cv = {32'd2, 32'd3, 32'd1, 32'd2};
    drive_check("R3", 2'b00, 128'h00000080_00000080_00000080_00000080, cv);
    drive_check("R3", 2'b01, 128'h00000080_00000080_00000080_00000080, cv);
    drive_check("R3", 2'b10, 128'h80000080_00000080_F0000080_00000080, cv);
  endtask

  task automatic t_high_bits;
    for (int b = 5; b < 64; b++) begin
      drive_check("R3", 2'(b % 3), 128'h89ABCDEF_80000000_0000FFFF_FEDCBA98,
                  128'(64'd1 << b) | 128'd3);
    end
  endtask

  task automatic t_upper_ignored;
    drive_check("R1", 2'b00, 128'hCAFEF00D_80000000_12345678_FFFFFFFF,
                {64'hFFFFFFFF_FFFFFFFF, 64'd5});
    drive_check("R1", 2'b01, 128'hCAFEF00D_80000000_12345678_FFFFFFFF,
                {64'h00000001_00000000, 64'd0});
    drive_check("R1", 2'b10, 128'hCAFEF00D_80000000_12345678_FFFFFFFF,
                {64'h80000000_00000020, 64'd31});
  endtask

  task automatic t_lane_isolation;
    drive_check("R8", 2'b01, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'd1);
    drive_check("R8", 2'b00, 128'hFFFFFFFF_FFFFFFFF_FFFFFFFF_FFFFFFFF, 128'd1);
    drive_check("R8", 2'b10, 128'h00000001_80000000_00000001_80000000, 128'd31);
    drive_check("R2", 2'b01, 128'h00000001_00000002_00000004_00000008, 128'd7);
  endtask

  task automatic t_sweep;
    for (int n = 0; n < 40; n++) begin
      for (int op = 0; op < 4; op++) begin
        logic [127:0] d;
        rng = next_rand(rng); d[31:0]   = rng;
        rng = next_rand(rng); d[63:32]  = rng | 32'h80000000;
        rng = next_rand(rng); d[95:64]  = rng & 32'h7FFFFFFF;
        rng = next_rand(rng); d[127:96] = rng;
        drive_check("R2", 2'(op), d, 128'(n));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks   = 0;
    errors   = 0;
    rng      = 32'h1F2E3D4C;
    rst_n    = 1'b0;
    op_sel   = 2'b00;
    data_in  = '0;
    count_in = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_zero_count();
    t_ops_small();
    t_boundary();
    t_lanes_as_count();
    t_high_bits();
    t_upper_ignored();
    t_lane_isolation();
    t_sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule